// File: doc/BRIEF.md
# Cached Page-Program Status Tracker

This block models, on the memory-device side, the status that a host sees while pages are programmed through a two-stage pipeline: a data cache that takes the next page's data, and a page buffer that holds the page being programmed. It decodes already-recognised command strobes for data load, cached program, final program, status read and reset. It keeps one ready flag for each stage and a two-deep history of program results, and drives a ready/busy level toward the host.

The array side reports two events. The first is a cache-to-buffer transfer done. The second is a program done, which carries a pass flag. A transfer into the page buffer is taken only when the buffer is free, so a cached page waits until the page ahead of it has finished programming. A status read captures a byte. In that byte each result bit is shown only while the flag that qualifies it says ready, so the host never sees a result that is out of date.

Top module: `cache_prog_status`

## Requirements
- R1: After `rst_n` is released, `busy_n` is 1, `status_q` is 8'h00, and both ready flags are set.
- R2: A `status_stb` pulse loads `status_q` at that clock edge. The status byte is laid out as follows: bit 5 is the page-buffer ready flag, bit 6 is the data-cache ready flag, bit 7 is the `wp_n` level, and bits 2 to 4 read 0. With nothing in progress and `wp_n` high, the byte is 8'hE0.
- R3: Bit 0 is 1 when the most recent program in the current sequence failed. It reads 0 while the page buffer is busy, and 0 when no page of the sequence has completed yet.
- R4: Bit 1 is 1 when the program before the most recent one failed. It reads 0 while the data cache is busy, and 0 when that slot does not hold a result from the current sequence, as on the first page.
- R5: A cached-program strobe is taken only after an accepted load strobe, with `wp_n` high and the data cache ready. Once taken, the cache is busy from the next cycle and `busy_n` follows the cache flag.
- R6: `xfer_done` is taken only while cached data is waiting and the page buffer is free, or is being freed by `pgm_done` in the same cycle. Once taken, the cache is ready and the buffer is busy. In any other case it is ignored.
- R7: `pgm_done` while the buffer is busy moves the current result into the previous slot, records the new result (fail = not `pgm_pass`), and frees the buffer. When the buffer is idle, `pgm_done` is ignored.
- R8: After a final-program strobe, `busy_n` stays 0 until both the page buffer and the data cache are ready.
- R9: While `wp_n` is low, load, cached-program and final-program strobes are ignored.
- R10: `reset_stb` clears both results to pass, sets both ready flags, discards waiting cache data and any armed load, and drives `busy_n` to 1 from the next cycle.
- R11: The first program strobe of a new sequence invalidates both result slots. The sequence ends when a page completes after a final program with no cached data waiting. Once that happens, both results from that sequence are shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_stb | input | 1 | Data-load command strobe |
| last_stb | input | 1 | Final-page program command strobe |
| cache_stb | input | 1 | Cached program command strobe |
| status_stb | input | 1 | Status-read command strobe |
| reset_stb | input | 1 | Reset command strobe |
| pgm_done | input | 1 | Array program finished (one cycle) |
| pgm_pass | input | 1 | Result qualifying `pgm_done`, 1 = pass |
| xfer_done | input | 1 | Cache-to-buffer transfer finished (one cycle) |
| wp_n | input | 1 | Write-protect level, low = protected |
| status_q | output | 8 | Captured status byte |
| busy_n | output | 1 | Ready/busy level, 0 = busy |

## Verification
The hardest state to reach is both stages busy at once: a cached page waits behind a page that is still programming, and a transfer strobe arrives that must be ignored. The stimulus reaches it by loading and issuing a cached program twice, with one accepted transfer between the two, before any program-done event. The same setup is reused to send `pgm_done` and `xfer_done` in the same cycle, and to show the previous-page result only after the final page's data has moved out of the cache.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned B_CUR   = 0;
  localparam int unsigned B_PREV  = 1;
  localparam int unsigned B_PBRDY = 5;
  localparam int unsigned B_DCRDY = 6;
  localparam int unsigned B_WP    = 7;

  typedef enum logic {RB_PAGE = 1'b0, RB_CACHE = 1'b1} rb_src_e;

  typedef struct packed {
    logic fail;
    logic valid;
  } result_t;

  function automatic logic [STAT_W-1:0] pack_status(input logic pb_rdy, input logic dc_rdy,
                                                    input logic wp_n, input result_t cur,
                                                    input result_t prev);
    logic [STAT_W-1:0] s;
    s          = '0;
    s[B_CUR]   = pb_rdy & cur.valid & cur.fail;
    s[B_PREV]  = dc_rdy & prev.valid & prev.fail;
    s[B_PBRDY] = pb_rdy;
    s[B_DCRDY] = dc_rdy;
    s[B_WP]    = wp_n;
    return s;
  endfunction

  function automatic logic rb_level(input rb_src_e src, input logic pb_rdy, input logic dc_rdy);
    return (src == RB_CACHE) ? dc_rdy : (pb_rdy & dc_rdy);
  endfunction
endpackage

// File: rtl/cps_cmd_gate.sv
module cps_cmd_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic load_stb,
  input  logic last_stb,
  input  logic cache_stb,
  input  logic reset_stb,
  input  logic wp_n,
  input  logic dc_rdy,
  output logic prog_go,
  output logic go_cache
);
  logic load_armed;
  logic load_ok;

  assign load_ok  = load_stb & wp_n & dc_rdy & ~reset_stb;
  assign prog_go  = load_armed & wp_n & dc_rdy & ~reset_stb & (last_stb | cache_stb);
  assign go_cache = cache_stb & ~last_stb;

  always_ff @(posedge clk) begin
    if (!rst_n)         load_armed <= 1'b0;
    else if (reset_stb) load_armed <= 1'b0;
    else if (prog_go)   load_armed <= 1'b0;
    else if (load_ok)   load_armed <= 1'b1;
  end

  // R9: a program strobe can never be taken while write protect is active
  assert_wp_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n) |-> !prog_go);
endmodule

// File: rtl/cps_flags.sv
module cps_flags
  import cps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reset_stb,
  input  logic    prog_go,
  input  logic    go_cache,
  input  logic    pgm_done,
  input  logic    xfer_done,
  output logic    pb_rdy,
  output logic    dc_rdy,
  output rb_src_e rb_src,
  output logic    done_ok,
  output logic    seq_start
);
  logic pb_busy, dc_busy, final_flag, seq_active;
  logic xfer_ok, seq_end;

  assign pb_rdy    = ~pb_busy;
  assign dc_rdy    = ~dc_busy;
  assign done_ok   = pgm_done & pb_busy & ~reset_stb;
  assign xfer_ok   = xfer_done & dc_busy & (~pb_busy | done_ok) & ~reset_stb;
  assign seq_start = prog_go & ~seq_active;
  assign seq_end   = done_ok & final_flag & ~dc_busy;

  always_ff @(posedge clk) begin
    if (!rst_n || reset_stb) begin
      pb_busy    <= 1'b0;
      dc_busy    <= 1'b0;
      final_flag <= 1'b0;
      seq_active <= 1'b0;
      rb_src     <= RB_PAGE;
    end else begin
      if (prog_go)      dc_busy <= 1'b1;
      else if (xfer_ok) dc_busy <= 1'b0;
      if (xfer_ok)      pb_busy <= 1'b1;
      else if (done_ok) pb_busy <= 1'b0;
      if (prog_go) begin
        rb_src     <= rb_src_e'(go_cache);
        final_flag <= ~go_cache;
      end
      if (prog_go)      seq_active <= 1'b1;
      else if (seq_end) seq_active <= 1'b0;
    end
  end

  // R6: the page buffer turns busy only as cached data leaves the cache
  assert_buf_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pb_busy) |-> $fell(dc_busy));
  // R7: the page buffer cannot stay busy across an accepted completion without a refill
  assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_done && pb_busy && !xfer_done && !reset_stb) |=> pb_rdy);
endmodule

// File: rtl/cps_results.sv
module cps_results
  import cps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    seq_start,
  input  logic    done_ok,
  input  logic    pgm_pass,
  output result_t cur,
  output result_t prev
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cur  <= '{fail: 1'b0, valid: 1'b0};
      prev <= '{fail: 1'b0, valid: 1'b0};
    end else if (seq_start) begin
      cur.valid  <= 1'b0;
      prev.valid <= 1'b0;
    end else if (done_ok) begin
      prev <= cur;
      cur  <= '{fail: ~pgm_pass, valid: 1'b1};
    end
  end

  // R7: the older slot receives what the newer slot held one cycle before
  assert_history_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !clr && !seq_start) |=> (prev == $past(cur)) && cur.valid);
  // R10: the reset command leaves both slots at pass
  assert_clear_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!cur.fail && !prev.fail));
endmodule

// File: rtl/cache_prog_status.sv
module cache_prog_status
  import cps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic              last_stb,
  input  logic              cache_stb,
  input  logic              status_stb,
  input  logic              reset_stb,
  input  logic              pgm_done,
  input  logic              pgm_pass,
  input  logic              xfer_done,
  input  logic              wp_n,
  output logic [STAT_W-1:0] status_q,
  output logic              busy_n
);
  logic    prog_go, go_cache, pb_rdy, dc_rdy, done_ok, seq_start;
  rb_src_e rb_src;
  result_t cur, prev;
  logic [STAT_W-1:0] status_now;

  cps_cmd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .last_stb(last_stb),
    .cache_stb(cache_stb), .reset_stb(reset_stb), .wp_n(wp_n), .dc_rdy(dc_rdy),
    .prog_go(prog_go), .go_cache(go_cache)
  );

  cps_flags u_flags (
    .clk(clk), .rst_n(rst_n), .reset_stb(reset_stb), .prog_go(prog_go),
    .go_cache(go_cache), .pgm_done(pgm_done), .xfer_done(xfer_done),
    .pb_rdy(pb_rdy), .dc_rdy(dc_rdy), .rb_src(rb_src), .done_ok(done_ok),
    .seq_start(seq_start)
  );

  cps_results u_res (
    .clk(clk), .rst_n(rst_n), .clr(reset_stb), .seq_start(seq_start),
    .done_ok(done_ok), .pgm_pass(pgm_pass), .cur(cur), .prev(prev)
  );

  assign status_now = pack_status(pb_rdy, dc_rdy, wp_n, cur, prev);
  assign busy_n     = rb_level(rb_src, pb_rdy, dc_rdy);

  always_ff @(posedge clk) begin
    if (!rst_n)          status_q <= '0;
    else if (status_stb) status_q <= status_now;
  end

  // R3: a busy page buffer hides the current result in the captured byte
  assert_cur_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_stb && !pb_rdy) |=> !status_q[B_CUR]);
  // R4: a busy data cache hides the previous result in the captured byte
  assert_prev_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_stb && !dc_rdy) |=> !status_q[B_PREV]);
  // R5: the cache turns busy only if write protect was off on that edge
  assert_cache_wp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dc_rdy) |-> $past(wp_n));
  // R10: the reset command releases the ready/busy level on the next cycle
  assert_ffh_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_stb |=> (busy_n && pb_rdy && dc_rdy));
endmodule

// File: tb/cache_prog_status_bench.sv
`timescale 1ns/1ps
module cache_prog_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_stb = 0, last_stb = 0, cache_stb = 0, status_stb = 0, reset_stb = 0;
  logic pgm_done = 0, pgm_pass = 0, xfer_done = 0, wp_n = 1'b1;
  logic [7:0] status_q;
  logic busy_n;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  localparam int LOAD = 0, LAST = 1, CACHE = 2, RST = 3, XFER = 4, DONE_P = 5, DONE_F = 6;

  always #4 clk = ~clk;

  cache_prog_status u_cache_prog_status (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .last_stb(last_stb),
    .cache_stb(cache_stb), .status_stb(status_stb), .reset_stb(reset_stb),
    .pgm_done(pgm_done), .pgm_pass(pgm_pass), .xfer_done(xfer_done), .wp_n(wp_n),
    .status_q(status_q), .busy_n(busy_n)
  );

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fire(input int which);
    case (which)
      LOAD:   load_stb  = 1;
      LAST:   last_stb  = 1;
      CACHE:  cache_stb = 1;
      RST:    reset_stb = 1;
      XFER:   xfer_done = 1;
      DONE_P: begin pgm_done = 1; pgm_pass = 1; end
      default: begin pgm_done = 1; pgm_pass = 0; end
    endcase
    @(negedge clk);
    {load_stb, last_stb, cache_stb, reset_stb, xfer_done, pgm_done, pgm_pass} = '0;
  endtask

  task automatic read_status(input logic [7:0] exp, input logic exp_busy_n, input string tag);
    check8({7'd0, busy_n}, {7'd0, exp_busy_n}, {tag, " busy_n"});
    status_stb = 1;
    @(negedge clk);
    status_stb = 0;
    check8(status_q, exp, {tag, " status"});
  endtask

  task automatic t_reset_state();
    check8(status_q, 8'h00, "R1 status after reset");
    read_status(8'hE0, 1, "R1/R2 idle");
  endtask

  task automatic t_cached_sequence();
    fire(LOAD); fire(CACHE);
    read_status(8'hA0, 0, "R5 cache busy");
    fire(XFER);
    read_status(8'hC0, 1, "R6 moved to buffer");
    fire(LOAD); fire(CACHE);
    fire(XFER);
    read_status(8'h80, 0, "R6 xfer ignored while buffer busy");
    fire(DONE_F);
    read_status(8'hA1, 0, "R3 first page fail, R4 prev invalid");
    fire(XFER);
    read_status(8'hC0, 1, "R4 first page prev invalid");
    fire(LOAD); fire(LAST);
    read_status(8'h80, 0, "R8 final queued");
    fire(DONE_P);
    read_status(8'hA0, 0, "R4 prev hidden while cache busy");
    fire(XFER);
    read_status(8'hC2, 0, "R8 busy with buffer busy, R4 prev fail");
    fire(DONE_F);
    read_status(8'hE1, 1, "R11 both results after final");
  endtask

  task automatic t_new_sequence();
    fire(LOAD); fire(LAST); fire(XFER); fire(DONE_P);
    read_status(8'hE0, 1, "R11 new sequence invalidates old fail");
  endtask

  task automatic t_idle_done();
    fire(DONE_F);
    read_status(8'hE0, 1, "R7 done ignored while idle");
  endtask

  task automatic t_write_protect();
    wp_n = 0;
    fire(LOAD); fire(CACHE);
    read_status(8'h60, 1, "R9 protected strobes ignored");
    wp_n = 1;
    fire(CACHE);
    read_status(8'hE0, 1, "R9 load was not armed");
  endtask

  task automatic t_same_cycle();
    fire(LOAD); fire(CACHE); fire(XFER); fire(LOAD); fire(CACHE);
    xfer_done = 1;
    fire(DONE_P);
    read_status(8'hC0, 1, "R6 transfer with same-cycle completion");
    fire(DONE_F);
    read_status(8'hE1, 1, "R7 history after overlap");
  endtask

  task automatic t_reset_cmd();
    fire(LOAD); fire(CACHE); fire(XFER); fire(LOAD); fire(CACHE);
    read_status(8'h80, 0, "R10 both busy before reset");
    fire(RST);
    read_status(8'hE0, 1, "R10 reset command");
    fire(XFER);
    read_status(8'hE0, 1, "R10 pending data dropped");
    fire(LOAD); fire(RST); fire(CACHE);
    read_status(8'hE0, 1, "R10 armed load dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_cached_sequence();
    t_new_sequence();
    t_idle_done();
    t_write_protect();
    t_same_cycle();
    t_reset_cmd();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule